// File: doc/BRIEF.md
# Asynchronous Host Register Bridge

This block lets an external host processor reach a bank of 32-bit configuration registers over an asynchronous bus. The bus has a 16-bit data path, a 9-bit byte address, a strobe, a read/write select and a size select. The host drives address, direction, size and write data, raises the strobe, and waits for the acknowledge. The host then drops the strobe and waits for the acknowledge to fall before it starts the next data phase. The strobe passes through a flop synchronizer into the block's clock. Address, data and control are sampled in the cycle the synchronized strobe is first seen high. By protocol they have been stable since the strobe rose.

Each 32-bit register spans two doublet addresses. The one with address bit 1 clear holds bits 31:16, and the one with address bit 1 set holds bits 15:0. Address bits 8:2 select the register. In 16-bit mode every data phase stands alone and carries its own address. In 32-bit mode the host gives an address in the first data phase only. The second phase goes to the lower half of the same register, whatever the host drives on the address lines. The data order is big endian: the upper half moves first. A 32-bit read freezes the whole register when its first phase is served, so the two halves belong together. A 32-bit write is staged and lands in one clock. Register 0 is a free-running counter that can also be loaded. It shows the difference between a coherent 32-bit read and two separate 16-bit reads.

Top module: `hreg_bridge`

## Requirements
- R1: After reset, h_ack, h_rdata and h_err are all 0, and every register, including the counter, holds 0.
- R2: The acknowledge rises exactly 3 clock edges after the strobe changes from low to high, counting the synchronizer (2 stages by default) and the phase register. It falls exactly 3 edges after the strobe changes from high to low. Each strobe pulse serves exactly one data phase.
- R3: A 16-bit read with h_rw=1 and h_s32=0 returns the live value of the addressed half. h_addr[8:2] selects the register. h_addr[1]=0 selects bits 31:16 and h_addr[1]=1 selects bits 15:0. A register index of NREG or more reads as 0.
- R4: A 16-bit write with h_rw=0 and h_s32=0 changes only the addressed half of the addressed register, at the edge where h_ack rises. A register index of NREG or more is ignored.
- R5: In a 32-bit access (h_s32=1), the first phase takes the address from h_addr. The second phase ignores h_addr and always addresses the lower half of that same register.
- R6: A 32-bit read returns bits 31:16 in the first phase and saves the whole register at that same edge. The second phase returns bits 15:0 of the saved copy, even if the live register has changed since.
- R7: A 32-bit write holds the first-phase data as the upper half. The full 32-bit value {first, second} is written in the single edge that serves the second phase.
- R8: A 32-bit access whose first-phase address has h_addr[1:0] not equal to 0 writes nothing, and both of its phases read 0. h_err is high for exactly one cycle, the same cycle in which the first phase's acknowledge rises.
- R9: Register 0 counts up by 1 on every clock edge. A read returns the count held just before the serving edge. A write sets the count, which then keeps counting. Two 16-bit reads of its halves can therefore disagree, while a 32-bit read is always one coherent sample.
- R10: h_rdata changes only at an edge where the acknowledge rises for a read phase. Write phases and idle time leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| h_strb | input | 1 | Host strobe, asynchronous, high while a data phase is requested |
| h_rw | input | 1 | Direction, 1 = read, 0 = write |
| h_s32 | input | 1 | Size select, 1 = 32-bit access in two phases, 0 = 16-bit access |
| h_addr | input | 9 | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Read data, valid while h_ack is high after a read phase |
| h_ack | output | 1 | Data phase acknowledge |
| h_err | output | 1 | One-cycle pulse on a misaligned 32-bit access |

## Verification
On every cycle, the assertions check that the acknowledge never rises or falls before the strobe has been steady long enough to pass the synchronizer. They also check that read data moves only when an acknowledge rises, and that the error pulse is one cycle wide and coincides with a rising acknowledge. The content side cannot be seen by a property on the ports: which half is returned, the snapshot and staging behaviour, rejected misaligned writes, and the counter's exact value. The bench's behavioural model covers these, compared on every clock. The counter scenarios load values just below a 16-bit wrap, so the bench can show a coherent 32-bit read next to a torn pair of 16-bit reads.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

    localparam int ADDR_W = 9;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int CNT_IDX = 0;

    typedef enum logic [1:0] {
        PH_NONE    = 2'd0,
        PH_SINGLE  = 2'd1,
        PH_QFIRST  = 2'd2,
        PH_QSECOND = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              kind;
        logic                rd;
        logic                bad;
        logic                half;   // 0 = bits 31:16, 1 = bits 15:0
        logic [IDX_W-1:0]    idx;
        logic [HALF_W-1:0]   wdata;
    } req_t;

    function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2];
    endfunction

    function automatic logic f_misaligned(input logic [ADDR_W-1:0] a);
        return a[1:0] != 2'b00;
    endfunction

    function automatic logic [HALF_W-1:0] f_pick(input logic [WORD_W-1:0] w, input logic lower);
        return lower ? w[HALF_W-1:0] : w[WORD_W-1:HALF_W];
    endfunction

endpackage

// File: rtl/hrb_handshake.sv
module hrb_handshake #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_a,
    output logic phase_go,
    output logic ack
);
    logic [STAGES-1:0] chain;
    logic              strb_s;
    logic              seen;

    assign strb_s   = chain[STAGES-1];
    assign phase_go = strb_s & ~seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            seen  <= 1'b0;
            ack   <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], strb_a};
            seen  <= strb_s;
            if (phase_go)
                ack <= 1'b1;
            else if (!strb_s)
                ack <= 1'b0;
        end
    end
endmodule

// File: rtl/hrb_seq.sv
module hrb_seq
    import hrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              h_rw,
    input  logic              h_s32,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [HALF_W-1:0] h_wdata,
    output req_t              req,
    output logic              err
);
    logic             in_quad;
    logic             q_bad;
    logic [IDX_W-1:0] q_idx;

    always_comb begin
        req       = '0;
        req.rd    = h_rw;
        req.wdata = h_wdata;
        if (go) begin
            if (in_quad) begin
                req.kind = PH_QSECOND;
                req.idx  = q_idx;
                req.half = 1'b1;
                req.bad  = q_bad;
            end else if (h_s32) begin
                req.kind = PH_QFIRST;
                req.idx  = f_idx(h_addr);
                req.half = 1'b0;
                req.bad  = f_misaligned(h_addr);
            end else begin
                req.kind = PH_SINGLE;
                req.idx  = f_idx(h_addr);
                req.half = h_addr[1];
                req.bad  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_quad <= 1'b0;
            q_bad   <= 1'b0;
            q_idx   <= '0;
            err     <= 1'b0;
        end else begin
            err <= go && !in_quad && h_s32 && f_misaligned(h_addr);
            if (go) begin
                if (in_quad) begin
                    in_quad <= 1'b0;
                end else if (h_s32) begin
                    in_quad <= 1'b1;
                    q_idx   <= f_idx(h_addr);
                    q_bad   <= f_misaligned(h_addr);
                end
            end
        end
    end
endmodule

// File: rtl/hrb_bank.sv
module hrb_bank
    import hrb_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    output logic [HALF_W-1:0] rdata
);
    logic [WORD_W-1:0] regs [NREG];
    logic [WORD_W-1:0] live;
    logic [WORD_W-1:0] next_word;
    logic [HALF_W-1:0] stage;
    logic [WORD_W-1:0] snap;
    logic              in_range;
    logic              commit;

    assign in_range = int'(req.idx) < NREG;

    always_comb begin
        live = '0;
        for (int i = 0; i < NREG; i++)
            if (req.idx == IDX_W'(i))
                live = regs[i];
    end

    always_comb begin
        commit    = 1'b0;
        next_word = live;
        if (!req.rd && in_range && !req.bad) begin
            case (req.kind)
                PH_SINGLE: begin
                    commit    = 1'b1;
                    next_word = req.half ? {live[WORD_W-1:HALF_W], req.wdata}
                                         : {req.wdata, live[HALF_W-1:0]};
                end
                PH_QSECOND: begin
                    commit    = 1'b1;
                    next_word = {stage, req.wdata};
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (commit && req.idx == IDX_W'(g))
                word_q <= next_word;
            else if (g == CNT_IDX)
                word_q <= word_q + WORD_W'(1);
        end
        assign regs[g] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            snap  <= '0;
            stage <= '0;
        end else if (req.rd) begin
            case (req.kind)
                PH_SINGLE:  rdata <= f_pick(live, req.half);
                PH_QFIRST: begin
                    snap  <= req.bad ? '0 : live;
                    rdata <= req.bad ? '0 : f_pick(live, 1'b0);
                end
                PH_QSECOND: rdata <= req.bad ? '0 : f_pick(snap, 1'b1);
                default: ;
            endcase
        end else if (req.kind == PH_QFIRST) begin
            stage <= req.wdata;
        end
    end
endmodule

// File: rtl/hreg_bridge.sv
module hreg_bridge
    import hrb_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_strb,
    input  logic              h_rw,
    input  logic              h_s32,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [HALF_W-1:0] h_wdata,
    output logic [HALF_W-1:0] h_rdata,
    output logic              h_ack,
    output logic              h_err
);
    logic phase_go;
    req_t req;

    hrb_handshake #(.STAGES(SYNC_STAGES)) u_hs (
        .clk(clk), .rst(rst), .strb_a(h_strb), .phase_go(phase_go), .ack(h_ack)
    );

    hrb_seq u_seq (
        .clk(clk), .rst(rst), .go(phase_go), .h_rw(h_rw), .h_s32(h_s32),
        .h_addr(h_addr), .h_wdata(h_wdata), .req(req), .err(h_err)
    );

    hrb_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst(rst), .req(req), .rdata(h_rdata)
    );
endmodule

// File: rtl/hrb_chk.sv
module hrb_chk #(
    parameter int STAGES = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        h_strb,
    input logic        h_ack,
    input logic        h_err,
    input logic [15:0] h_rdata
);
    logic [3:0] hi_cnt;
    logic [3:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= h_strb ? ((hi_cnt == 4'hF) ? hi_cnt : hi_cnt + 4'd1) : 4'd0;
            lo_cnt <= !h_strb ? ((lo_cnt == 4'hF) ? lo_cnt : lo_cnt + 4'd1) : 4'd0;
        end
    end

    assert_ack_rise_after_strb_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(h_ack) |-> hi_cnt >= 4'(STAGES + 1));

    assert_ack_fall_after_strb_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(h_ack) |-> lo_cnt >= 4'(STAGES + 1));

    assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        h_err |=> !h_err);

    assert_err_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
        h_err |-> $rose(h_ack));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$rose(h_ack) |-> $stable(h_rdata));
endmodule

bind hreg_bridge hrb_chk #(.STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .h_strb(h_strb), .h_ack(h_ack), .h_err(h_err), .h_rdata(h_rdata)
);

// File: tb/test_hreg_bridge.sv
`timescale 1ns/1ps
module test_hreg_bridge;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_strb = 1'b0, h_rw = 1'b1, h_s32 = 1'b0;
    logic [8:0]  h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_ack, h_err;

    always #10 clk = ~clk;

    hreg_bridge #(.NREG(NREG)) i_hreg_bridge (
        .clk(clk), .rst(rst), .h_strb(h_strb), .h_rw(h_rw), .h_s32(h_s32),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .h_err(h_err)
    );

    int    n_vec = 0, n_bad = 0;
    string cur_tag = "R1 reset";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] regs_m [NREG];
    logic [31:0] snap_m;
    logic [15:0] stage_m, exp_rd;
    logic        quad_m, bad_m, exp_err, ack_prev, started = 1'b0, rst_q;
    int          qidx_m;

    always @(posedge clk) rst_q <= rst;

    function automatic logic [31:0] word_m(input int idx);
        return (idx < NREG) ? regs_m[idx] : 32'h0;
    endfunction

    always @(negedge clk) begin
        logic wrote0;
        int   idx;
        logic [31:0] w;
        if (rst_q === 1'b1) begin
            started = 1'b1;
            foreach (regs_m[i]) regs_m[i] = '0;
            snap_m = '0; stage_m = '0; quad_m = 0; bad_m = 0; qidx_m = 0;
            exp_rd = '0; exp_err = 0; ack_prev = 0;
        end else if (started) begin
            exp_err = 0;
            wrote0  = 0;
            if (h_ack && !ack_prev) begin
                if (quad_m) begin
                    quad_m = 0;
                    if (h_rw) exp_rd = bad_m ? 16'h0 : snap_m[15:0];
                    else if (!bad_m && qidx_m < NREG) begin
                        regs_m[qidx_m] = {stage_m, h_wdata};
                        if (qidx_m == 0) wrote0 = 1;
                    end
                end else if (h_s32) begin
                    quad_m = 1;
                    qidx_m = int'(h_addr[8:2]);
                    bad_m  = h_addr[1:0] != 2'b00;
                    exp_err = bad_m;
                    if (h_rw) begin
                        snap_m = bad_m ? 32'h0 : word_m(qidx_m);
                        exp_rd = snap_m[31:16];
                    end else stage_m = h_wdata;
                end else begin
                    idx = int'(h_addr[8:2]);
                    w = word_m(idx);
                    if (h_rw) exp_rd = h_addr[1] ? w[15:0] : w[31:16];
                    else if (idx < NREG) begin
                        if (h_addr[1]) regs_m[idx] = {w[31:16], h_wdata};
                        else           regs_m[idx] = {h_wdata, w[15:0]};
                        if (idx == 0) wrote0 = 1;
                    end
                end
            end
            if (!wrote0) regs_m[0] = regs_m[0] + 1;
            ack_prev = h_ack;
        end
        if (started) begin
            chk({cur_tag, " rdata"}, {16'h0, h_rdata}, {16'h0, exp_rd});
            chk({cur_tag, " err"}, {31'h0, h_err}, {31'h0, exp_err});
        end
    end

    // ---------------- host bus driver ----------------
    task automatic phase(input logic rw, input logic s32, input logic [8:0] a,
                         input logic [15:0] d, input string tag, output logic [15:0] rd);
        int lat;
        @(posedge clk); #2;
        cur_tag = tag;
        h_rw = rw; h_s32 = s32; h_addr = a; h_wdata = d; h_strb = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!h_ack && lat < 40);
        chk({tag, " R2 ack rise latency"}, 32'(lat), 32'd4);
        rd = h_rdata;
        @(posedge clk); #2;
        h_strb = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (h_ack && lat < 40);
        chk({tag, " R2 ack fall latency"}, 32'(lat), 32'd4);
    endtask

    initial begin
        #4000000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r, hi, lo, keep;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 ack after reset", {31'h0, h_ack}, 32'h0);
        chk("R1 rdata after reset", {16'h0, h_rdata}, 32'h0);
        @(posedge clk); #2 rst = 1'b0;

        phase(1, 0, 9'h000, 0, "R1 counter upper after reset", r);
        chk("R1 counter upper", {16'h0, r}, 32'h0);
        phase(1, 0, 9'h00C, 0, "R1 reg3 after reset", r);
        chk("R1 reg3 lower", {16'h0, r}, 32'h0);

        // 16-bit accesses
        phase(0, 0, 9'h00C, 16'hA5A5, "R4 write reg3 upper", r);
        phase(0, 0, 9'h00E, 16'h5A5A, "R4 write reg3 lower", r);
        phase(1, 0, 9'h00C, 0, "R3 read reg3 upper", r);
        chk("R3 reg3 upper", {16'h0, r}, 32'hA5A5);
        phase(0, 0, 9'h00C, 16'h1234, "R4 rewrite reg3 upper", r);
        chk("R10 rdata kept over write", {16'h0, h_rdata}, 32'hA5A5);
        phase(1, 0, 9'h00E, 0, "R4 reg3 lower untouched", r);
        chk("R4 reg3 lower", {16'h0, r}, 32'h5A5A);
        phase(1, 0, 9'h00D, 0, "R3 addr bit0 ignored", r);
        chk("R3 reg3 upper via odd", {16'h0, r}, 32'h1234);

        // 32-bit write then reads
        phase(0, 1, 9'h014, 16'hDEAD, "R7 write reg5 first", r);
        phase(0, 1, 9'h014, 16'hBEEF, "R7 write reg5 second", r);
        phase(1, 0, 9'h014, 0, "R7 reg5 upper", r);
        chk("R7 reg5 upper", {16'h0, r}, 32'hDEAD);
        phase(1, 0, 9'h016, 0, "R7 reg5 lower", r);
        chk("R7 reg5 lower", {16'h0, r}, 32'hBEEF);
        phase(1, 1, 9'h014, 0, "R6 read reg5 first", hi);
        phase(1, 1, 9'h1F2, 0, "R5 read reg5 second odd addr", lo);
        chk("R6 reg5 quad", {hi, lo}, 32'hDEADBEEF);

        // out of range
        phase(0, 0, 9'h040, 16'h7777, "R4 write out of range", r);
        phase(1, 0, 9'h040, 0, "R3 read out of range", r);
        chk("R3 out of range reads 0", {16'h0, r}, 32'h0);

        // misaligned 32-bit accesses
        phase(0, 1, 9'h016, 16'h1111, "R8 bad write first", r);
        phase(0, 1, 9'h016, 16'h2222, "R8 bad write second", r);
        phase(1, 1, 9'h014, 0, "R8 reg5 after bad write first", hi);
        phase(1, 1, 9'h014, 0, "R8 reg5 after bad write second", lo);
        chk("R8 reg5 unchanged", {hi, lo}, 32'hDEADBEEF);
        phase(1, 1, 9'h015, 0, "R8 bad read first", hi);
        phase(1, 1, 9'h015, 0, "R8 bad read second", lo);
        chk("R8 bad read zero", {hi, lo}, 32'h0);

        // counter: coherent 32-bit read across a low-half wrap
        phase(0, 1, 9'h000, 16'h0001, "R9 load counter first", r);
        phase(0, 1, 9'h000, 16'hFFF0, "R9 load counter second", r);
        phase(1, 1, 9'h000, 0, "R9 quad read first", hi);
        repeat (40) @(posedge clk);
        phase(1, 1, 9'h000, 0, "R9 quad read second", lo);
        chk("R9 coherent upper", {16'h0, hi}, 32'h0001);
        chk("R9 coherent lower pre-wrap", {31'h0, lo >= 16'hFFF0}, 32'h1);
        phase(1, 0, 9'h000, 0, "R9 live upper moved", r);
        chk("R9 live upper", {16'h0, r}, 32'h0002);

        // counter: torn pair of 16-bit reads
        phase(0, 1, 9'h000, 16'h0000, "R9 reload first", r);
        phase(0, 1, 9'h000, 16'hFFC0, "R9 reload second", r);
        phase(1, 0, 9'h000, 0, "R9 single upper", hi);
        repeat (80) @(posedge clk);
        phase(1, 0, 9'h002, 0, "R9 single lower", lo);
        chk("R9 torn upper", {16'h0, hi}, 32'h0000);
        chk("R9 torn lower wrapped", {31'h0, lo < 16'hFFC0}, 32'h1);
        keep = h_rdata;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R10 rdata idle hold", {16'h0, h_rdata}, {16'h0, keep});

        repeat (5) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule